// File: doc/BRIEF.md
# Thermometer-Coded Clock Deskew Controller

This controller sets the delay of one deskew buffer in a clock zone. Each cycle a phase detector may report whether the zone clock leads or trails the reference. A filter turns runs of matching reports into single delay steps. The delay lives in a thermometer-coded register, and each set bit asks an external delay line for one fixed step of about 8.5 ps. The default width of 20 bits spans roughly 170 ps.

A serial test port sits beside the loop. It can sample the stored setting and shift it out, and it can shift in a new setting and commit it. This lets bring-up tune a zone by hand or add skew on purpose. A freeze input stops the loop so that a committed value stays in place. An active-low enable forces the delay-line code to zero without losing the stored setting. A lock flag reports that the loop is dithering around the balance point.

Top module: `dsk_ctrl`

## Requirements
- R1: After reset the delay code is all zeros, the lock flag is low and the serial output is 0.
- R2: A filtered "more delay" step shifts the code one place toward the top bit, with a 1 entering bit 0.
- R3: A filtered "less delay" step shifts the code one place toward bit 0, with a 0 entering the top bit.
- R4: A step is taken only on the FILT_N-th consecutive accepted decision in the same direction. Cycles with no valid decision neither count nor break a run. A reversal restarts the run at one. After a step the run restarts from zero.
- R5: The code saturates: further increase steps leave an all-ones code unchanged, and further decrease steps leave an all-zeros code unchanged.
- R6: The lock flag rises once LOCK_M consecutive accepted decisions have each reversed the previous direction. It drops on the first accepted decision that repeats the previous direction.
- R7: Serial read works as follows. A capture cycle copies the stored code into the shadow register. The serial output always shows shadow bit 0. Each shift cycle moves the shadow one bit toward bit 0, and the serial input enters the top bit.
- R8: An update cycle writes the shadow into the stored code. It wins over a loop step in the same cycle.
- R9: While freeze is high, decisions are ignored. The code, the filter run and the lock state stay unchanged.
- R10: While the active-low enable is high, the delay output is all zeros and decisions are ignored. The stored code is kept and reappears when the enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_ni | input | 1 | Active-low buffer enable; high forces minimum delay |
| freeze_i | input | 1 | Stops loop updates |
| dec_valid_i | input | 1 | A phase decision is present this cycle |
| dec_up_i | input | 1 | 1 = request more delay, 0 = request less delay |
| tap_capture_i | input | 1 | Copy stored code into the shadow register |
| tap_shift_i | input | 1 | Shift the shadow register one bit |
| tap_update_i | input | 1 | Commit the shadow register to the stored code |
| tap_sdi_i | input | 1 | Serial data in (enters top bit) |
| tap_sdo_o | output | 1 | Serial data out (shadow bit 0) |
| dly_o | output | DLY_W | Thermometer delay code to the delay line |
| locked_o | output | 1 | Loop is alternating around balance |

## Verification
The bench breaks an up-run with an idle cycle. A filter that clears its run on an idle cycle would step one decision late. It drives six alternations followed by one repeat. A lock counter that is off by one, or that never clears, shows up there. It holds the code at all-ones and all-zeros and keeps pushing outward. A shift that wraps or injects the wrong bit would corrupt the code. It commits a write in the same cycle as a filtered step. The wrong priority would leave the stepped value in place. Last, it steps while disabled and while frozen. A gate that cleared the stored code, or let the loop run, would not restore the prior setting.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
  } dsk_step_t;
endpackage

// File: rtl/dsk_filter.sv
module dsk_filter #(
  parameter int FILT_N = 4,
  parameter int LOCK_M = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_ok_i,
  input  logic              dec_up_i,
  output dsk_pkg::dsk_step_t step_o,
  output logic              locked_o
);
  localparam int RUN_W = $clog2(FILT_N + 1);
  localparam int ALT_W = $clog2(LOCK_M + 1);

  logic             have_prev_q, last_up_q;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic [ALT_W-1:0] alt_q, alt_nxt;
  logic             same, fire;

  assign same    = have_prev_q && (dec_up_i == last_up_q);
  assign run_nxt = same ? run_q + 1'b1 : RUN_W'(1);
  assign fire    = dec_ok_i && (run_nxt == RUN_W'(FILT_N));

  always_comb begin
    if (have_prev_q && !same)
      alt_nxt = (alt_q == ALT_W'(LOCK_M)) ? alt_q : alt_q + 1'b1;
    else
      alt_nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      last_up_q   <= 1'b0;
      run_q       <= '0;
      alt_q       <= '0;
    end else if (dec_ok_i) begin
      have_prev_q <= 1'b1;
      last_up_q   <= dec_up_i;
      run_q       <= fire ? '0 : run_nxt;
      alt_q       <= alt_nxt;
    end
  end

  assign step_o.inc = fire && dec_up_i;
  assign step_o.dec = fire && !dec_up_i;
  assign locked_o   = (alt_q == ALT_W'(LOCK_M));
endmodule

// File: rtl/dsk_therm_reg.sv
module dsk_therm_reg #(
  parameter int DLY_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DLY_W-1:0]   wr_data_i,
  input  dsk_pkg::dsk_step_t step_i,
  output logic [DLY_W-1:0]   q_o
);
  logic [DLY_W-1:0] q, q_inc, q_dec;

  for (genvar i = 0; i < DLY_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign q_inc[i] = 1'b1;
    end else begin : g_lo_n
      assign q_inc[i] = q[i-1];
    end
    if (i == DLY_W - 1) begin : g_hi
      assign q_dec[i] = 1'b0;
    end else begin : g_hi_n
      assign q_dec[i] = q[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q <= '0;
    else if (wr_i)        q <= wr_data_i;  // test write beats the loop
    else if (step_i.inc)  q <= q_inc;
    else if (step_i.dec)  q <= q_dec;
  end

  assign q_o = q;
endmodule

// File: rtl/dsk_scan.sv
module dsk_scan #(
  parameter int DLY_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             sdi_i,
  input  logic [DLY_W-1:0] par_i,
  output logic             sdo_o,
  output logic [DLY_W-1:0] shadow_o
);
  logic [DLY_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (capture_i) sh_q <= par_i;
    else if (shift_i)   sh_q <= {sdi_i, sh_q[DLY_W-1:1]};
  end

  assign sdo_o    = sh_q[0];
  assign shadow_o = sh_q;
endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl #(
  parameter int DLY_W  = 20,
  parameter int FILT_N = 4,
  parameter int LOCK_M = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             freeze_i,
  input  logic             dec_valid_i,
  input  logic             dec_up_i,
  input  logic             tap_capture_i,
  input  logic             tap_shift_i,
  input  logic             tap_update_i,
  input  logic             tap_sdi_i,
  output logic             tap_sdo_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             locked_o
);
  dsk_pkg::dsk_step_t step;
  logic [DLY_W-1:0]   dly_q, shadow_q;
  logic               dec_ok;

  assign dec_ok = dec_valid_i && !freeze_i && !en_ni;

  dsk_filter #(.FILT_N(FILT_N), .LOCK_M(LOCK_M)) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_ok_i (dec_ok),
    .dec_up_i (dec_up_i),
    .step_o   (step),
    .locked_o (locked_o)
  );

  dsk_therm_reg #(.DLY_W(DLY_W)) i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (tap_update_i),
    .wr_data_i (shadow_q),
    .step_i    (step),
    .q_o       (dly_q)
  );

  dsk_scan #(.DLY_W(DLY_W)) i_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (tap_capture_i),
    .shift_i   (tap_shift_i),
    .sdi_i     (tap_sdi_i),
    .par_i     (dly_q),
    .sdo_o     (tap_sdo_o),
    .shadow_o  (shadow_q)
  );

  assign dly_o = en_ni ? '0 : dly_q;
endmodule

// File: rtl/dsk_ctrl_chk.sv
module dsk_ctrl_chk #(
  parameter int DLY_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_ni,
  input logic             freeze_i,
  input logic             tap_update_i,
  input logic [DLY_W-1:0] dly_q,
  input logic [DLY_W-1:0] shadow_q
);
  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && !tap_update_i) |=> $stable(dly_q)); // R10

  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !tap_update_i) |=> $stable(dly_q)); // R9

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_update_i |=> (dly_q == $past(shadow_q))); // R8

  AST_STEP_UP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tap_update_i |=> ($countones(dly_q) <= $countones($past(dly_q)) + 1)); // R2

  AST_STEP_DN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tap_update_i |=> ($countones(dly_q) + 1 >= $countones($past(dly_q)))); // R3
endmodule

bind dsk_ctrl dsk_ctrl_chk #(.DLY_W(DLY_W)) i_dsk_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_ni        (en_ni),
  .freeze_i     (freeze_i),
  .tap_update_i (tap_update_i),
  .dly_q        (dly_q),
  .shadow_q     (shadow_q)
);

// File: tb/test_dsk_ctrl.sv
`timescale 1ns/1ps
module test_dsk_ctrl;
  localparam int W = 20;
  localparam int NV = 22;
  // {valid, up, ones[4:0], locked}
  localparam logic [7:0] VEC [NV] = '{
    {1'b1,1'b1,5'd0,1'b0}, {1'b1,1'b1,5'd0,1'b0}, {1'b1,1'b1,5'd0,1'b0},
    {1'b1,1'b1,5'd1,1'b0}, {1'b1,1'b1,5'd1,1'b0}, {1'b0,1'b0,5'd1,1'b0},
    {1'b1,1'b1,5'd1,1'b0}, {1'b1,1'b1,5'd1,1'b0}, {1'b1,1'b1,5'd2,1'b0},
    {1'b1,1'b0,5'd2,1'b0}, {1'b1,1'b1,5'd2,1'b0}, {1'b1,1'b0,5'd2,1'b0},
    {1'b1,1'b1,5'd2,1'b0}, {1'b1,1'b0,5'd2,1'b0}, {1'b1,1'b1,5'd2,1'b1},
    {1'b1,1'b1,5'd2,1'b0}, {1'b1,1'b1,5'd2,1'b0}, {1'b1,1'b1,5'd3,1'b0},
    {1'b1,1'b0,5'd3,1'b0}, {1'b1,1'b0,5'd3,1'b0}, {1'b1,1'b0,5'd3,1'b0},
    {1'b1,1'b0,5'd2,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b0, freeze = 1'b0, dv = 1'b0, up = 1'b0;
  logic cap = 1'b0, sh = 1'b0, upd = 1'b0, sdi = 1'b0;
  logic sdo, locked;
  logic [W-1:0] dly;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsk_ctrl i_dsk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .freeze_i(freeze),
    .dec_valid_i(dv), .dec_up_i(up), .tap_capture_i(cap), .tap_shift_i(sh),
    .tap_update_i(upd), .tap_sdi_i(sdi), .tap_sdo_o(sdo), .dly_o(dly),
    .locked_o(locked)
  );

  function automatic logic [W-1:0] therm(int k);
    logic [31:0] v;
    v = (32'd1 << k) - 32'd1;
    return v[W-1:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_n = 1'b0; freeze = 1'b0; dv = 1'b0; up = 1'b0;
    cap = 1'b0; sh = 1'b0; upd = 1'b0; sdi = 1'b0;
    tick(); rst_n = 1'b1; tick();
  endtask

  task automatic decide(logic d, int n);
    for (int i = 0; i < n; i++) begin dv = 1'b1; up = d; tick(); end
    dv = 1'b0;
  endtask

  task automatic load_shadow(logic [W-1:0] v);
    for (int i = 0; i < W; i++) begin sdi = v[i]; sh = 1'b1; tick(); end
    sh = 1'b0;
  endtask

  task automatic tap_write(logic [W-1:0] v);
    load_shadow(v);
    upd = 1'b1; tick(); upd = 1'b0;
  endtask

  task automatic tap_read(output logic [W-1:0] v);
    cap = 1'b1; tick(); cap = 1'b0;
    for (int i = 0; i < W; i++) begin v[i] = sdo; sh = 1'b1; tick(); end
    sh = 1'b0;
  endtask

  initial begin
    logic [W-1:0] rd;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 dly", dly, '0);
    check("R1 locked", locked, 0);
    check("R1 sdo", sdo, 0);

    // table: R2 R4 R6 R3
    for (int v = 0; v < NV; v++) begin
      dv = VEC[v][7]; up = VEC[v][6];
      tick();
      check("R2/R3/R4 table dly", dly, therm(int'(VEC[v][5:1])));
      check("R6 table locked", locked, VEC[v][0]);
    end
    dv = 1'b0;

    // R7 read back stored value
    tap_read(rd);
    check("R7 read", rd, therm(2));

    // R10 disable: output zero, decisions ignored, value kept
    en_n = 1'b1; tick();
    check("R10 forced zero", dly, '0);
    decide(1'b1, 8);
    check("R10 still zero", dly, '0);
    en_n = 1'b0; tick();
    check("R10 restored", dly, therm(2));

    // R9 freeze
    freeze = 1'b1; decide(1'b1, 8); freeze = 1'b0;
    check("R9 frozen", dly, therm(2));

    // R8 write
    tap_write(20'hA5C3F);
    check("R8 write", dly, 20'hA5C3F);
    tap_read(rd);
    check("R7 read written", rd, 20'hA5C3F);

    // R8 priority over same-cycle step
    do_reset();
    decide(1'b1, 3);
    load_shadow(20'h0F0F0);
    dv = 1'b1; up = 1'b1; upd = 1'b1; tick();
    dv = 1'b0; upd = 1'b0;
    check("R8 priority", dly, 20'h0F0F0);

    // R5 saturation high
    do_reset();
    tap_write(therm(W));
    decide(1'b1, 8);
    check("R5 sat high", dly, therm(W));
    // R5 saturation low
    tap_write('0);
    decide(1'b0, 8);
    check("R5 sat low", dly, '0);

    // R3 decrease from top: 0 enters top bit
    tap_write(20'h80001);
    decide(1'b0, 4);
    check("R3 shift down", dly, 20'h40000);
    // R2 increase: 1 enters bit 0
    decide(1'b1, 4);
    check("R2 shift up", dly, 20'h80001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule